// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers event pulses from a DMA engine and from a SCSI bus controller into three sticky status bytes. It reduces them, through per-source enable masks, to a summary byte and one registered, level-sensitive interrupt line. Each status byte clears when its read strobe is pulsed.

In the same cycle it decides whether a newly raised event must stop the embedded script sequencer, and pulses `halt_req` when it must. That decision uses its own masking rule rather than the interrupt enables. Some SCSI events stop the sequencer even when their interrupt is disabled. A selection timeout is never acted on when it is raised: it waits until the sequencer starts an instruction that drives the bus.

Software can also abort the sequencer, set or clear an interrupt-on-the-fly flag, and put the sequencer into single-step mode. In that mode every completed instruction raises a DMA status bit and a halt.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register returns to zero. After that edge `summary`, `irq`, `halt_req`, `scsi0_status` and `scsi1_status` read 0, and `dma_status` reads 0x80.
- R2: `summary` bit 0 is 1 exactly when the DMA status byte ANDed with the DMA enable byte is nonzero.
- R3: `summary` bit 1 is 1 exactly when (SCSI0 status AND SCSI0 enable) or (SCSI1 status AND SCSI1 enable) is nonzero.
- R4: `irq` is a register. After each edge it equals the OR of `summary` bits 0, 1 and 2 as they stand after that same edge, so a read that clears a status byte also drops `irq` in that cycle.
- R5: A status byte takes the OR of its old value and the event pulses at each edge. When its read strobe is high at the edge, the old value is discarded first, so an event in that same cycle survives and nothing older does.
- R6: `dma_status` always shows bit 7 as 1. A DMA event on bit 7 is not stored and does not halt.
- R7: A `summary` write stores only data bits 7:4, which appear unchanged on `summary[7:4]`. Bit 3 always reads 0. Writing 1 to data bit 2 clears the on-the-fly flag (`summary` bit 2). `onfly_set` sets it, and a set wins over a clear in the same cycle.
- R8: A `summary` write with data bit 7 set raises DMA status bit 4 (abort, 0x10) and pulses `halt_req` after that edge.
- R9: SCSI0 bits are parity 0x01, bus reset 0x02, unexpected disconnect 0x04, gross error 0x08, reselected 0x10, selected 0x20, function complete 0x40 and phase mismatch 0x80. A raised SCSI0 event halts if it is enabled. Bits 0x01, 0x02, 0x04, 0x08 and 0x80 also halt when disabled. Bits 0x10, 0x20 and 0x40 halt only when enabled.
- R10: SCSI1 bits are handshake timeout 0x01, general timer 0x02 and selection timeout 0x04. Bits 0x01 and 0x02 halt only when enabled. Raising 0x04 never halts by itself. `halt_req` pulses after an edge where `bus_insn` is high while the stored SCSI1 bit 0x04 is set.
- R11: While the stored control bit 4 (single step, written through `ctl_wdata`) is 1, an `insn_done` pulse raises DMA status bit 3 (0x08) and a halt.
- R12: Any DMA event on bits 6:0, whether external, abort or single step, pulses `halt_req` after the edge at which it is raised.
- R13: SCSI1 status bits 7:3 and SCSI1 enable bits 7:3 are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_evt | input | 8 | DMA event pulses, one per status bit |
| scsi0_evt | input | 8 | SCSI0 event pulses |
| scsi1_evt | input | 8 | SCSI1 event pulses (bits 2:0 used) |
| dma_en_we | input | 1 | Write strobe for the DMA enable byte |
| dma_en_wdata | input | 8 | DMA enable write data |
| scsi0_en_we | input | 1 | Write strobe for the SCSI0 enable byte |
| scsi0_en_wdata | input | 8 | SCSI0 enable write data |
| scsi1_en_we | input | 1 | Write strobe for the SCSI1 enable byte |
| scsi1_en_wdata | input | 8 | SCSI1 enable write data |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control write data, bit 4 is single step |
| sum_we | input | 1 | Write strobe for the summary byte |
| sum_wdata | input | 8 | Summary write data |
| onfly_set | input | 1 | Sets the on-the-fly flag |
| dma_rd | input | 1 | Read strobe, clears DMA status |
| scsi0_rd | input | 1 | Read strobe, clears SCSI0 status |
| scsi1_rd | input | 1 | Read strobe, clears SCSI1 status |
| insn_done | input | 1 | Sequencer finished an instruction |
| bus_insn | input | 1 | Sequencer starts an instruction that touches the bus |
| summary | output | 8 | Summary byte |
| irq | output | 1 | Level interrupt, registered |
| halt_req | output | 1 | One-cycle request to stop the sequencer |
| dma_status | output | 8 | DMA status, bit 7 forced to 1 |
| scsi0_status | output | 8 | SCSI0 status |
| scsi1_status | output | 8 | SCSI1 status |

## Verification
A read strobe and a fresh event pulse can land on the same status byte in the same cycle. In that cycle the block must discard the old contents, keep the new event, and recompute the summary and `irq` from the result. The bench forces this pairing with a directed SCSI0 case. Random traffic then produces the same pairing on all three bytes, together with a simultaneous set and clear of the on-the-fly flag. A per-cycle reference model decides the outcome, and the status bytes, `summary`, `irq` and `halt_req` are all compared after every edge.

// File: rtl/irqagg_pkg.sv
// Package: shared constants for the interrupt status aggregator.
// Assumes status bytes are 8 bits wide and sources are indexed DMA, SCSI0, SCSI1.
package irqagg_pkg;
    localparam int STAT_W  = 8;
    localparam int NUM_SRC = 3;

    localparam int SRC_DMA   = 0;
    localparam int SRC_SCSI0 = 1;
    localparam int SRC_SCSI1 = 2;

    // Storable bits of each status byte
    localparam logic [STAT_W-1:0] DMA_VALID = 8'h7F;
    localparam logic [STAT_W-1:0] S0_VALID  = 8'hFF;
    localparam logic [STAT_W-1:0] S1_VALID  = 8'h07;

    // Internally raised DMA causes
    localparam logic [STAT_W-1:0] DMA_ABORT = 8'h10;
    localparam logic [STAT_W-1:0] DMA_STEP  = 8'h08;

    // SCSI0 events that halt only when enabled: complete, selected, reselected
    localparam logic [STAT_W-1:0] S0_SOFT   = 8'h70;
    // SCSI1 timers that halt only when enabled
    localparam logic [STAT_W-1:0] S1_TIMERS = 8'h03;
    // SCSI1 selection timeout, deferred until a bus instruction
    localparam logic [STAT_W-1:0] S1_SELTO  = 8'h04;

    localparam int SUM_ONFLY_BIT = 2;
    localparam int SUM_ABORT_BIT = 7;
    localparam int CTL_STEP_BIT  = 4;

    typedef struct packed {
        logic [3:0] upper;
        logic       rsvd;
        logic       onfly;
        logic       scsi_pend;
        logic       dma_pend;
    } summary_t;

    // Returns the mask of storable bits for a source index.
    function automatic logic [STAT_W-1:0] src_valid(input int idx);
        case (idx)
            SRC_DMA:   return DMA_VALID;
            SRC_SCSI0: return S0_VALID;
            default:   return S1_VALID;
        endcase
    endfunction
endpackage

// File: rtl/irqagg_status_bank.sv
// Module: one sticky status byte with clear-on-read.
// Assumes set pulses and the read strobe are synchronous to clk; a read
// discards the old contents while events of the same cycle are kept.
module irqagg_status_bank #(
    parameter int              W     = 8,
    parameter logic [W-1:0]    VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_d
);
    // Next value: cleared on read, then merged with new events.
    always_comb begin
        stat_d = (clr_i ? '0 : stat_q) | (set_i & VALID);
    end

    // Status storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/irqagg_halt_policy.sv
// Module: decides whether the events of this cycle must stop the sequencer.
// Assumes dma_set is already limited to storable DMA bits; uses its own
// masking rule, independent of the interrupt enables for SCSI0 hard errors.
module irqagg_halt_policy
    import irqagg_pkg::*;
(
    input  logic [STAT_W-1:0] dma_set,
    input  logic [STAT_W-1:0] s0_evt,
    input  logic [STAT_W-1:0] s1_evt,
    input  logic [STAT_W-1:0] s0_en,
    input  logic [STAT_W-1:0] s1_en,
    input  logic [STAT_W-1:0] s1_stat_q,
    input  logic              bus_insn,
    output logic              halt_now
);
    logic dma_halt, s0_halt, s1_halt, selto_halt;

    // Combine each halt cause.
    always_comb begin
        dma_halt   = |dma_set;
        s0_halt    = |(s0_evt & (s0_en | ~S0_SOFT));
        s1_halt    = |(s1_evt & s1_en & S1_TIMERS);
        selto_halt = bus_insn & (|(s1_stat_q & S1_SELTO));
        halt_now   = dma_halt | s0_halt | s1_halt | selto_halt;
    end
endmodule

// File: rtl/irqagg_summary.sv
// Module: enable masks, summary byte and the registered interrupt line.
// Assumes status next-state values arrive from the banks so the interrupt
// register lines up with the status registers in the same cycle.
module irqagg_summary
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we    [NUM_SRC],
    input  logic [STAT_W-1:0] en_wdata [NUM_SRC],
    input  logic [STAT_W-1:0] stat_q   [NUM_SRC],
    input  logic [STAT_W-1:0] stat_d   [NUM_SRC],
    input  logic              sum_we,
    input  logic [STAT_W-1:0] sum_wdata,
    input  logic              onfly_set,
    output logic [STAT_W-1:0] en_q     [NUM_SRC],
    output summary_t          summary,
    output logic              irq
);
    logic [STAT_W-1:0] en_d [NUM_SRC];
    logic [3:0]        upper_q;
    logic              onfly_q, onfly_d;
    logic              dma_pend_d, scsi_pend_d;

    // Enable registers, one per source, limited to storable bits.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        always_comb begin
            en_d[i] = en_we[i] ? (en_wdata[i] & src_valid(i)) : en_q[i];
        end

        // Holds the enable mask of source i.
        always_ff @(posedge clk) begin
            if (!rst_n) en_q[i] <= '0;
            else        en_q[i] <= en_d[i];
        end
    end

    // On-the-fly flag next state: a set wins over a write-one clear.
    always_comb begin
        onfly_d = onfly_set | (onfly_q & ~(sum_we & sum_wdata[SUM_ONFLY_BIT]));
    end

    // Pending bits computed from next-state values for the interrupt register.
    always_comb begin
        dma_pend_d  = |(stat_d[SRC_DMA] & en_d[SRC_DMA]);
        scsi_pend_d = |(stat_d[SRC_SCSI0] & en_d[SRC_SCSI0])
                    | |(stat_d[SRC_SCSI1] & en_d[SRC_SCSI1]);
    end

    // Upper nibble, flag and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            onfly_q <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (sum_we) upper_q <= sum_wdata[7:4];
            onfly_q <= onfly_d;
            irq     <= dma_pend_d | scsi_pend_d | onfly_d;
        end
    end

    // Summary byte assembled from stored state.
    always_comb begin
        summary.upper     = upper_q;
        summary.rsvd      = 1'b0;
        summary.onfly     = onfly_q;
        summary.dma_pend  = |(stat_q[SRC_DMA] & en_q[SRC_DMA]);
        summary.scsi_pend = |(stat_q[SRC_SCSI0] & en_q[SRC_SCSI0])
                          | |(stat_q[SRC_SCSI1] & en_q[SRC_SCSI1]);
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt status aggregator.
// Gathers DMA and SCSI event pulses into status bytes, derives the summary
// byte and interrupt line, and raises a one-cycle halt request for the
// script sequencer. Assumes all inputs are synchronous to clk.
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] dma_evt,
    input  logic [7:0] scsi0_evt,
    input  logic [7:0] scsi1_evt,
    input  logic       dma_en_we,
    input  logic [7:0] dma_en_wdata,
    input  logic       scsi0_en_we,
    input  logic [7:0] scsi0_en_wdata,
    input  logic       scsi1_en_we,
    input  logic [7:0] scsi1_en_wdata,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       sum_we,
    input  logic [7:0] sum_wdata,
    input  logic       onfly_set,
    input  logic       dma_rd,
    input  logic       scsi0_rd,
    input  logic       scsi1_rd,
    input  logic       insn_done,
    input  logic       bus_insn,
    output logic [7:0] summary,
    output logic       irq,
    output logic       halt_req,
    output logic [7:0] dma_status,
    output logic [7:0] scsi0_status,
    output logic [7:0] scsi1_status
);
    logic [STAT_W-1:0] set_a    [NUM_SRC];
    logic              clr_a    [NUM_SRC];
    logic [STAT_W-1:0] stat_q   [NUM_SRC];
    logic [STAT_W-1:0] stat_d   [NUM_SRC];
    logic              en_we    [NUM_SRC];
    logic [STAT_W-1:0] en_wdata [NUM_SRC];
    logic [STAT_W-1:0] en_q     [NUM_SRC];
    logic [STAT_W-1:0] dma_int;
    logic              step_q;
    logic              halt_now;
    summary_t          sum_s;

    // Internally raised DMA causes: abort by summary write, single step.
    always_comb begin
        dma_int = '0;
        if (sum_we && sum_wdata[SUM_ABORT_BIT]) dma_int = dma_int | DMA_ABORT;
        if (insn_done && step_q)                dma_int = dma_int | DMA_STEP;
    end

    // Route per-source set, clear and enable-write signals into arrays.
    always_comb begin
        set_a[SRC_DMA]      = dma_evt | dma_int;
        set_a[SRC_SCSI0]    = scsi0_evt;
        set_a[SRC_SCSI1]    = scsi1_evt;
        clr_a[SRC_DMA]      = dma_rd;
        clr_a[SRC_SCSI0]    = scsi0_rd;
        clr_a[SRC_SCSI1]    = scsi1_rd;
        en_we[SRC_DMA]      = dma_en_we;
        en_we[SRC_SCSI0]    = scsi0_en_we;
        en_we[SRC_SCSI1]    = scsi1_en_we;
        en_wdata[SRC_DMA]   = dma_en_wdata;
        en_wdata[SRC_SCSI0] = scsi0_en_wdata;
        en_wdata[SRC_SCSI1] = scsi1_en_wdata;
    end

    // One status bank per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bank
        irqagg_status_bank #(
            .W     (STAT_W),
            .VALID (src_valid(i))
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_a[i]),
            .clr_i  (clr_a[i]),
            .stat_q (stat_q[i]),
            .stat_d (stat_d[i])
        );
    end

    irqagg_summary u_summary (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .stat_q    (stat_q),
        .stat_d    (stat_d),
        .sum_we    (sum_we),
        .sum_wdata (sum_wdata),
        .onfly_set (onfly_set),
        .en_q      (en_q),
        .summary   (sum_s),
        .irq       (irq)
    );

    irqagg_halt_policy u_halt (
        .dma_set   (set_a[SRC_DMA] & DMA_VALID),
        .s0_evt    (scsi0_evt),
        .s1_evt    (scsi1_evt),
        .s0_en     (en_q[SRC_SCSI0]),
        .s1_en     (en_q[SRC_SCSI1]),
        .s1_stat_q (stat_q[SRC_SCSI1]),
        .bus_insn  (bus_insn),
        .halt_now  (halt_now)
    );

    // Single-step control bit and halt pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= 1'b0;
            halt_req <= 1'b0;
        end else begin
            if (ctl_we) step_q <= ctl_wdata[CTL_STEP_BIT];
            halt_req <= halt_now;
        end
    end

    // Drive the visible status and summary bytes.
    always_comb begin
        summary      = sum_s;
        dma_status   = stat_q[SRC_DMA] | 8'h80;
        scsi0_status = stat_q[SRC_SCSI0];
        scsi1_status = stat_q[SRC_SCSI1];
    end
endmodule

// File: rtl/irqagg_checker.sv
// Module: temporal checks on the aggregator ports, bound to the top.
module irqagg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] scsi0_evt,
    input logic       scsi0_rd,
    input logic       sum_we,
    input logic [7:0] sum_wdata,
    input logic [7:0] summary,
    input logic       irq,
    input logic       halt_req,
    input logic [7:0] dma_status,
    input logic [7:0] scsi0_status,
    input logic [7:0] scsi1_status
);
    // R1: a reset edge leaves the outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !halt_req && summary == 8'h00));

    // R4: the interrupt line tracks the summary pending bits
    a_r4_irq_tracks_summary: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|summary[2:0]));

    // R5: a read keeps only the events of the same cycle
    a_r5_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        scsi0_rd |=> scsi0_status == $past(scsi0_evt));

    // R6: DMA status bit 7 always reads as one
    a_r6_dma_top_set: assert property (@(posedge clk) disable iff (!rst_n)
        dma_status[7]);

    // R7: a summary write stores the upper nibble and bit 3 stays zero
    a_r7_upper_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        sum_we |=> (summary[7:4] == $past(sum_wdata[7:4]) && !summary[3]));

    // R8: abort raises DMA status bit 4 and a halt
    a_r8_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_we && sum_wdata[7]) |=> (halt_req && dma_status[4]));

    // R13: SCSI1 upper bits never set
    a_r13_s1_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        scsi1_status[7:3] == 5'b0);
endmodule

bind irq_aggregator irqagg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scsi0_evt    (scsi0_evt),
    .scsi0_rd     (scsi0_rd),
    .sum_we       (sum_we),
    .sum_wdata    (sum_wdata),
    .summary      (summary),
    .irq          (irq),
    .halt_req     (halt_req),
    .dma_status   (dma_status),
    .scsi0_status (scsi0_status),
    .scsi1_status (scsi1_status)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 100000;
    localparam int RAND_CYCLES  = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dma_evt, scsi0_evt, scsi1_evt;
    logic       dma_en_we, scsi0_en_we, scsi1_en_we, ctl_we, sum_we;
    logic [7:0] dma_en_wdata, scsi0_en_wdata, scsi1_en_wdata, ctl_wdata, sum_wdata;
    logic       onfly_set, dma_rd, scsi0_rd, scsi1_rd, insn_done, bus_insn;
    logic [7:0] summary, dma_status, scsi0_status, scsi1_status;
    logic       irq, halt_req;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    logic [7:0] m_stat [3];
    logic [7:0] m_en   [3];
    logic [3:0] m_upper;
    logic       m_onfly, m_step, m_irq, m_halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n),
        .dma_evt(dma_evt), .scsi0_evt(scsi0_evt), .scsi1_evt(scsi1_evt),
        .dma_en_we(dma_en_we), .dma_en_wdata(dma_en_wdata),
        .scsi0_en_we(scsi0_en_we), .scsi0_en_wdata(scsi0_en_wdata),
        .scsi1_en_we(scsi1_en_we), .scsi1_en_wdata(scsi1_en_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sum_we(sum_we), .sum_wdata(sum_wdata), .onfly_set(onfly_set),
        .dma_rd(dma_rd), .scsi0_rd(scsi0_rd), .scsi1_rd(scsi1_rd),
        .insn_done(insn_done), .bus_insn(bus_insn),
        .summary(summary), .irq(irq), .halt_req(halt_req),
        .dma_status(dma_status), .scsi0_status(scsi0_status),
        .scsi1_status(scsi1_status)
    );

    task automatic expect8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic expect1(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_summary();
        logic dp, sp;
        dp = |(m_stat[0] & m_en[0]);
        sp = |(m_stat[1] & m_en[1]) | |(m_stat[2] & m_en[2]);
        return {m_upper, 1'b0, m_onfly, sp, dp};
    endfunction

    // Advance the model by one edge from the current inputs.
    task automatic model_step();
        logic [7:0] dset, s_n [3], e_n [3];
        logic       o_n, h_n;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_stat[i] = 8'h00; m_en[i] = 8'h00; end
            m_upper = 4'h0; m_onfly = 0; m_step = 0; m_irq = 0; m_halt = 0;
            return;
        end
        dset = dma_evt & 8'h7F;
        if (sum_we && sum_wdata[7]) dset = dset | 8'h10;
        if (insn_done && m_step)    dset = dset | 8'h08;
        s_n[0] = (dma_rd   ? 8'h00 : m_stat[0]) | dset;
        s_n[1] = (scsi0_rd ? 8'h00 : m_stat[1]) | scsi0_evt;
        s_n[2] = (scsi1_rd ? 8'h00 : m_stat[2]) | (scsi1_evt & 8'h07);
        e_n[0] = dma_en_we   ? dma_en_wdata : m_en[0];
        e_n[1] = scsi0_en_we ? scsi0_en_wdata : m_en[1];
        e_n[2] = scsi1_en_we ? (scsi1_en_wdata & 8'h07) : m_en[2];
        o_n = onfly_set | (m_onfly & ~(sum_we & sum_wdata[2]));
        h_n = (|dset) | (|(scsi0_evt & (m_en[1] | 8'h8F)))
            | (|(scsi1_evt & m_en[2] & 8'h03)) | (bus_insn & m_stat[2][2]);
        m_irq = (|(s_n[0] & e_n[0])) | (|(s_n[1] & e_n[1])) | (|(s_n[2] & e_n[2])) | o_n;
        m_halt = h_n;
        if (sum_we) m_upper = sum_wdata[7:4];
        if (ctl_we) m_step = ctl_wdata[4];
        m_onfly = o_n;
        for (int i = 0; i < 3; i++) begin m_stat[i] = s_n[i]; m_en[i] = e_n[i]; end
    endtask

    task automatic compare();
        expect8(summary, exp_summary(), "R2 R3 R7 summary");
        expect1(irq, m_irq, "R4 irq");
        expect1(halt_req, m_halt, "R8 R9 R10 R11 R12 halt_req");
        expect8(dma_status, m_stat[0] | 8'h80, "R5 R6 dma_status");
        expect8(scsi0_status, m_stat[1], "R5 scsi0_status");
        expect8(scsi1_status, m_stat[2], "R5 R13 scsi1_status");
    endtask

    task automatic idle();
        dma_evt = 0; scsi0_evt = 0; scsi1_evt = 0;
        dma_en_we = 0; scsi0_en_we = 0; scsi1_en_we = 0; ctl_we = 0; sum_we = 0;
        dma_en_wdata = 0; scsi0_en_wdata = 0; scsi1_en_wdata = 0; ctl_wdata = 0; sum_wdata = 0;
        onfly_set = 0; dma_rd = 0; scsi0_rd = 0; scsi1_rd = 0; insn_done = 0; bus_insn = 0;
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        idle();
        rst_n = 1'b0;
        repeat (3) cyc();
        // R1 reset state
        expect8(summary, 8'h00, "R1 summary");
        expect1(irq, 1'b0, "R1 irq");
        expect8(dma_status, 8'h80, "R1 dma_status");
        rst_n = 1'b1;
        cyc();

        // R9 policy
        scsi0_evt = 8'h10; cyc();
        expect1(halt_req, 1'b0, "R9 disabled reselect");
        scsi0_evt = 8'h80; cyc();
        expect1(halt_req, 1'b1, "R9 mismatch halts while disabled");
        scsi0_en_we = 1; scsi0_en_wdata = 8'h10; cyc();
        scsi0_evt = 8'h10; cyc();
        expect1(halt_req, 1'b1, "R9 enabled reselect");
        expect1(irq, 1'b1, "R3 enabled scsi0 pending");

        // R5 read and event in one cycle
        scsi0_rd = 1; scsi0_evt = 8'h01; cyc();
        expect8(scsi0_status, 8'h01, "R5 read with event");
        expect1(irq, 1'b0, "R4 recomputed after read");
        scsi0_rd = 1; cyc();

        // R10 selection timeout deferral
        scsi1_en_we = 1; scsi1_en_wdata = 8'hFF; cyc();
        scsi1_evt = 8'h04; cyc();
        expect1(halt_req, 1'b0, "R10 timeout raise");
        expect1(irq, 1'b1, "R3 scsi1 pending");
        bus_insn = 1; cyc();
        expect1(halt_req, 1'b1, "R10 bus instruction");
        scsi1_evt = 8'hF9; cyc();
        expect8(scsi1_status, 8'h05, "R13 upper bits ignored");
        scsi1_en_we = 1; scsi1_en_wdata = 8'h00; scsi1_rd = 1; cyc();
        scsi1_evt = 8'h02; cyc();
        expect1(halt_req, 1'b0, "R10 timer disabled");
        scsi1_rd = 1; cyc();

        // R7 summary write and on-the-fly flag
        sum_we = 1; sum_wdata = 8'h5F; cyc();
        expect8(summary, 8'h50, "R7 upper nibble");
        onfly_set = 1; cyc();
        expect8(summary, 8'h54, "R7 flag set");
        expect1(irq, 1'b1, "R4 flag drives irq");
        onfly_set = 1; sum_we = 1; sum_wdata = 8'h04; cyc();
        expect8(summary, 8'h04, "R7 set wins");
        sum_we = 1; sum_wdata = 8'h04; cyc();
        expect8(summary, 8'h00, "R7 write one clears");

        // R8 abort
        sum_we = 1; sum_wdata = 8'h80; cyc();
        expect1(halt_req, 1'b1, "R8 abort halt");
        expect8(dma_status, 8'h90, "R8 abort status");
        dma_rd = 1; cyc();
        dma_evt = 8'h80; cyc();
        expect8(dma_status, 8'h80, "R6 bit 7 not stored");
        expect1(halt_req, 1'b0, "R6 bit 7 no halt");

        // R11 single step
        ctl_we = 1; ctl_wdata = 8'h10; cyc();
        insn_done = 1; cyc();
        expect8(dma_status, 8'h88, "R11 step status");
        expect1(halt_req, 1'b1, "R11 step halt");
        ctl_we = 1; ctl_wdata = 8'h00; dma_rd = 1; cyc();
        insn_done = 1; cyc();
        expect1(halt_req, 1'b0, "R11 step off");

        // R12 and R2
        dma_en_we = 1; dma_en_wdata = 8'h01; cyc();
        dma_evt = 8'h01; cyc();
        expect1(halt_req, 1'b1, "R12 dma event halt");
        expect1(summary[0], 1'b1, "R2 dma pending");
        dma_rd = 1; cyc();
        expect1(irq, 1'b0, "R2 cleared by read");

        // Constrained random traffic
        for (int n = 0; n < RAND_CYCLES; n++) begin
            if ($urandom % 6 == 0) dma_evt   = 8'($urandom);
            if ($urandom % 6 == 0) scsi0_evt = 8'($urandom);
            if ($urandom % 6 == 0) scsi1_evt = 8'($urandom);
            if ($urandom % 16 == 0) begin dma_en_we = 1;   dma_en_wdata = 8'($urandom); end
            if ($urandom % 16 == 0) begin scsi0_en_we = 1; scsi0_en_wdata = 8'($urandom); end
            if ($urandom % 16 == 0) begin scsi1_en_we = 1; scsi1_en_wdata = 8'($urandom); end
            if ($urandom % 20 == 0) begin ctl_we = 1;      ctl_wdata = 8'($urandom); end
            if ($urandom % 12 == 0) begin sum_we = 1;      sum_wdata = 8'($urandom); end
            onfly_set = ($urandom % 10 == 0);
            dma_rd    = ($urandom % 5 == 0);
            scsi0_rd  = ($urandom % 5 == 0);
            scsi1_rd  = ($urandom % 5 == 0);
            insn_done = ($urandom % 3 == 0);
            bus_insn  = ($urandom % 4 == 0);
            if ($urandom % 500 == 0) rst_n = 1'b0;
            cyc();
            rst_n = 1'b1;
        end
        report();
    end
endmodule